// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block is a pair of address generators. They run side by side so that two operands can be fetched in the same cycle, for example one from data memory and one from program memory. Each generator has three sets of four registers: pointers, step values and ring lengths. An access names one pointer and one step register. The generator puts the named pointer on its address output in that cycle. At the following clock edge it adds the chosen step to that pointer.

When the pointer's ring length is zero, the step is a plain add that wraps modulo 2^AW. When the length is nonzero, the pointer moves inside a ring. The ring starts at the pointer value with its low bits cleared, up to the smallest power of two that is at least the length, and it spans exactly `length` addresses. If a step carries the pointer past the top of the ring, the length is subtracted. If it carries the pointer below the ring start, the length is added.

Software writes and reads all registers through one shared port, and chooses the unit, the register kind and the register number. When a write and an access hit the same pointer in the same cycle, the written value is the one that is kept.

Top module: `dual_agen`

## Requirements
- R1: After reset every pointer, step and length register of both units reads back as zero.
- R2: A write with kind code 0 (pointer), 1 (step) or 2 (length) stores `wr_data` into register `wr_sel` of unit `wr_unit`, and the readback port shows it from the next cycle. Kind code 3 is reserved: a write with it changes no register, and reading it returns zero.
- R3: In every cycle, `addr_a` and `addr_b` equal the current value of the pointer chosen by that unit's pointer select, before any update.
- R4: When the pointer's length is zero, an access replaces the pointer with pointer + step. The step is read as a signed AW-bit value, and the result wraps modulo 2^AW.
- R5: When the length L is nonzero and pointer + step is above base + L - 1, the new pointer is pointer + step - L. The base is the pointer with its low bits cleared to the smallest power of two that is at least L.
- R6: When the length L is nonzero and pointer + step is below base, the new pointer is pointer + step + L.
- R7: The two units are independent. Accesses in the same cycle on both units each update only their own pointer, using their own step and length registers.
- R8: If a pointer write and an access to the same pointer of the same unit fall in one cycle, the pointer takes the written value. The address output in that cycle still shows the old value.
- R9: An access changes no register other than the pointer it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_unit | input | 1 | Unit selected for the write (0 = A, 1 = B) |
| wr_kind | input | 2 | Register kind for the write: 0 pointer, 1 step, 2 length, 3 reserved |
| wr_sel | input | SW | Register number for the write |
| wr_data | input | AW | Write data |
| rd_unit | input | 1 | Unit selected for readback |
| rd_kind | input | 2 | Register kind for readback |
| rd_sel | input | SW | Register number for readback |
| rd_data | output | AW | Readback value (combinational) |
| acc_a_en | input | 1 | Access strobe, unit A |
| acc_a_ptr | input | SW | Pointer select, unit A |
| acc_a_mod | input | SW | Step select, unit A |
| addr_a | output | AW | Address, unit A |
| acc_b_en | input | 1 | Access strobe, unit B |
| acc_b_ptr | input | SW | Pointer select, unit B |
| acc_b_mod | input | SW | Step select, unit B |
| addr_b | output | AW | Address, unit B |

## Verification
Each pointer is a state register that feeds back into itself. A wrong wrap decision or a wrong step therefore persists, and it shows on `addr_a` or `addr_b` the next time that pointer is selected, one cycle after the faulty update. Because the address outputs follow the pointer select in every cycle, the reference model compares both of them on every clock, along with the readback port. A corrupted step or length register shows up directly on `rd_data`. It also shows up indirectly on the next access that uses it. A write that loses a collision is visible on the address one cycle later.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [1:0] {
    KIND_IDX = 2'd0,
    KIND_MOD = 2'd1,
    KIND_LEN = 2'd2,
    KIND_RSV = 2'd3
  } reg_kind_e;

  // Copies every set bit into all lower positions: the result is 2^k-1,
  // the smallest such value that is at least v.
  function automatic logic [31:0] fill_right(input logic [31:0] v);
    logic [31:0] r;
    r = v;
    r = r | (r >> 1);
    r = r | (r >> 2);
    r = r | (r >> 4);
    r = r | (r >> 8);
    r = r | (r >> 16);
    return r;
  endfunction

endpackage

// File: rtl/agen_wrap.sv
module agen_wrap
  import agen_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt,
  output logic          wrap_hi,
  output logic          wrap_lo
);
  localparam int EW = AW + 2;

  logic [AW-1:0]        mask;
  logic [AW-1:0]        base;
  logic signed [EW-1:0] sum_s;
  logic signed [EW-1:0] base_s;
  logic signed [EW-1:0] top_s;
  logic signed [EW-1:0] len_s;
  logic signed [EW-1:0] res_s;
  logic                 ring_on;

  function automatic logic signed [EW-1:0] sext_step(input logic [AW-1:0] v);
    return signed'({{2{v[AW-1]}}, v});
  endfunction

  function automatic logic signed [EW-1:0] zext(input logic [AW-1:0] v);
    return signed'({2'b00, v});
  endfunction

  always_comb begin
    ring_on = (len != '0);
    mask    = AW'(fill_right(32'(len) - 32'd1));
    base    = cur & ~mask;
    len_s   = zext(len);
    base_s  = zext(base);
    top_s   = base_s + len_s - EW'(1);
    sum_s   = zext(cur) + sext_step(step);
    wrap_hi = ring_on && (sum_s > top_s);
    wrap_lo = ring_on && !wrap_hi && (sum_s < base_s);
    if (wrap_hi)      res_s = sum_s - len_s;
    else if (wrap_lo) res_s = sum_s + len_s;
    else              res_s = sum_s;
    nxt = res_s[AW-1:0];
  end

endmodule

// File: rtl/agen_bank.sv
module agen_bank #(
  parameter int AW   = 14,
  parameter int NREG = 4,
  parameter int SW   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SW-1:0]             wr_sel,
  input  logic [AW-1:0]             wr_data,
  input  logic                      upd_en,
  input  logic [SW-1:0]             upd_sel,
  input  logic [AW-1:0]             upd_data,
  output logic [NREG-1:0][AW-1:0]   regs
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [AW-1:0] q;
    logic          hit_wr;
    logic          hit_upd;
    assign hit_wr  = wr_en  && (wr_sel  == SW'(g));
    assign hit_upd = upd_en && (upd_sel == SW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (hit_wr)  q <= wr_data;
      else if (hit_upd) q <= upd_data;
    end
    assign regs[g] = q;
  end

endmodule

// File: rtl/agen_unit.sv
module agen_unit
  import agen_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  parameter int SW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_kind,
  input  logic [SW-1:0] rd_sel,
  output logic [AW-1:0] rd_val,
  input  logic          acc_en,
  input  logic [SW-1:0] acc_ptr,
  input  logic [SW-1:0] acc_mod,
  output logic [AW-1:0] addr,
  output logic          obs_fire,
  output logic [AW-1:0] obs_cur,
  output logic [AW-1:0] obs_step,
  output logic [AW-1:0] obs_len,
  output logic [AW-1:0] obs_nxt,
  output logic          obs_hi,
  output logic          obs_lo,
  output logic          obs_col
);
  localparam int NBANK = 3;

  logic [NBANK-1:0][NPTR-1:0][AW-1:0] bank_q;
  logic [NBANK-1:0]                   bank_wr;
  logic [AW-1:0]                      cur_ptr;
  logic [AW-1:0]                      cur_step;
  logic [AW-1:0]                      cur_len;
  logic [AW-1:0]                      step_nxt;
  logic                               hi_evt;
  logic                               lo_evt;

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    assign bank_wr[k] = wr_en && (wr_kind == 2'(k));
    agen_bank #(.AW(AW), .NREG(NPTR), .SW(SW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_wr[k]),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .upd_en   ((k == 0) ? acc_en : 1'b0),
      .upd_sel  (acc_ptr),
      .upd_data (step_nxt),
      .regs     (bank_q[k])
    );
  end

  assign cur_ptr  = bank_q[0][acc_ptr];
  assign cur_step = bank_q[1][acc_mod];
  assign cur_len  = bank_q[2][acc_ptr];

  agen_wrap #(.AW(AW)) u_wrap (
    .cur     (cur_ptr),
    .step    (cur_step),
    .len     (cur_len),
    .nxt     (step_nxt),
    .wrap_hi (hi_evt),
    .wrap_lo (lo_evt)
  );

  assign addr = cur_ptr;

  always_comb begin
    unique case (rd_kind)
      KIND_IDX: rd_val = bank_q[0][rd_sel];
      KIND_MOD: rd_val = bank_q[1][rd_sel];
      KIND_LEN: rd_val = bank_q[2][rd_sel];
      default:  rd_val = '0;
    endcase
  end

  assign obs_fire = acc_en;
  assign obs_cur  = cur_ptr;
  assign obs_step = cur_step;
  assign obs_len  = cur_len;
  assign obs_nxt  = step_nxt;
  assign obs_hi   = acc_en && hi_evt;
  assign obs_lo   = acc_en && lo_evt;
  assign obs_col  = acc_en && bank_wr[0] && (wr_sel == acc_ptr);

endmodule

// File: rtl/dual_agen.sv
module dual_agen #(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  parameter int SW   = $clog2(NPTR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_unit,
  input  logic [1:0]    wr_kind,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          rd_unit,
  input  logic [1:0]    rd_kind,
  input  logic [SW-1:0] rd_sel,
  output logic [AW-1:0] rd_data,
  input  logic          acc_a_en,
  input  logic [SW-1:0] acc_a_ptr,
  input  logic [SW-1:0] acc_a_mod,
  output logic [AW-1:0] addr_a,
  input  logic          acc_b_en,
  input  logic [SW-1:0] acc_b_ptr,
  input  logic [SW-1:0] acc_b_mod,
  output logic [AW-1:0] addr_b
);
  localparam int NUNIT = 2;

  logic [NUNIT-1:0]           en_v;
  logic [NUNIT-1:0][SW-1:0]   ptr_v;
  logic [NUNIT-1:0][SW-1:0]   mod_v;
  logic [NUNIT-1:0][AW-1:0]   addr_v;
  logic [NUNIT-1:0][AW-1:0]   rdv_v;
  logic [NUNIT-1:0]           obs_fire;
  logic [NUNIT-1:0][AW-1:0]   obs_cur;
  logic [NUNIT-1:0][AW-1:0]   obs_step;
  logic [NUNIT-1:0][AW-1:0]   obs_len;
  logic [NUNIT-1:0][AW-1:0]   obs_nxt;
  logic [NUNIT-1:0]           obs_hi;
  logic [NUNIT-1:0]           obs_lo;
  logic [NUNIT-1:0]           obs_col;

  assign en_v  = {acc_b_en,  acc_a_en};
  assign ptr_v = {acc_b_ptr, acc_a_ptr};
  assign mod_v = {acc_b_mod, acc_a_mod};

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    agen_unit #(.AW(AW), .NPTR(NPTR), .SW(SW)) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (wr_unit == 1'(u))),
      .wr_kind  (wr_kind),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .rd_kind  (rd_kind),
      .rd_sel   (rd_sel),
      .rd_val   (rdv_v[u]),
      .acc_en   (en_v[u]),
      .acc_ptr  (ptr_v[u]),
      .acc_mod  (mod_v[u]),
      .addr     (addr_v[u]),
      .obs_fire (obs_fire[u]),
      .obs_cur  (obs_cur[u]),
      .obs_step (obs_step[u]),
      .obs_len  (obs_len[u]),
      .obs_nxt  (obs_nxt[u]),
      .obs_hi   (obs_hi[u]),
      .obs_lo   (obs_lo[u]),
      .obs_col  (obs_col[u])
    );
  end

  assign addr_a  = addr_v[0];
  assign addr_b  = addr_v[1];
  assign rd_data = rd_unit ? rdv_v[1] : rdv_v[0];

endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int AW = 14,
  parameter int SW = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                wr_unit,
  input logic [1:0]          wr_kind,
  input logic [AW-1:0]       wr_data,
  input logic                rd_unit,
  input logic [1:0]          rd_kind,
  input logic [SW-1:0]       rd_sel,
  input logic [AW-1:0]       rd_data,
  input logic [SW-1:0]       acc_a_ptr,
  input logic [AW-1:0]       addr_a,
  input logic [1:0]          obs_fire,
  input logic [1:0][AW-1:0]  obs_cur,
  input logic [1:0][AW-1:0]  obs_step,
  input logic [1:0][AW-1:0]  obs_len,
  input logic [1:0][AW-1:0]  obs_nxt,
  input logic [1:0]          obs_hi,
  input logic [1:0]          obs_lo,
  input logic [1:0]          obs_col
);

  function automatic int signed_step(input logic [AW-1:0] m);
    return m[AW-1] ? int'(m) - (1 << AW) : int'(m);
  endfunction

  function automatic int ring_span(input logic [AW-1:0] l);
    int p;
    p = 1;
    for (int k = 0; k <= AW; k++) if (p < int'(l)) p = p * 2;
    return p;
  endfunction

  function automatic bit in_ring(input logic [AW-1:0] a, input logic [AW-1:0] anchor,
                                 input logic [AW-1:0] l);
    int p;
    int b;
    p = ring_span(l);
    b = (int'(anchor) / p) * p;
    return (int'(a) >= b) && (int'(a) < b + int'(l));
  endfunction

  function automatic bit small_step(input logic [AW-1:0] m, input logic [AW-1:0] l);
    int s;
    s = signed_step(m);
    return (s < int'(l)) && (-s < int'(l));
  endfunction

  for (genvar u = 0; u < 2; u++) begin : g_chk
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (obs_fire[u] && obs_len[u] == '0)
        |-> (obs_nxt[u] == AW'(int'(obs_cur[u]) + signed_step(obs_step[u])))); // R4

    AST_STAYS_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      (obs_fire[u] && obs_len[u] != '0 && in_ring(obs_cur[u], obs_cur[u], obs_len[u])
        && small_step(obs_step[u], obs_len[u]))
        |-> in_ring(obs_nxt[u], obs_cur[u], obs_len[u])); // R5

    AST_HIGH_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (obs_hi[u] && in_ring(obs_cur[u], obs_cur[u], obs_len[u]))
        |-> (signed_step(obs_step[u]) > 0)); // R5

    AST_LOW_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (obs_lo[u] && in_ring(obs_cur[u], obs_cur[u], obs_len[u]))
        |-> (signed_step(obs_step[u]) < 0)); // R6
  end

  AST_ADDR_IS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_unit && rd_kind == 2'd0 && rd_sel == acc_a_ptr) |-> (rd_data == addr_a)); // R3

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_col[0] && wr_en && !wr_unit && wr_kind == 2'd0)
      |=> (acc_a_ptr != $past(acc_a_ptr) || addr_a == $past(wr_data))); // R8

endmodule

bind dual_agen agen_checker #(.AW(AW), .SW(SW)) u_agen_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_unit   (wr_unit),
  .wr_kind   (wr_kind),
  .wr_data   (wr_data),
  .rd_unit   (rd_unit),
  .rd_kind   (rd_kind),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .acc_a_ptr (acc_a_ptr),
  .addr_a    (addr_a),
  .obs_fire  (obs_fire),
  .obs_cur   (obs_cur),
  .obs_step  (obs_step),
  .obs_len   (obs_len),
  .obs_nxt   (obs_nxt),
  .obs_hi    (obs_hi),
  .obs_lo    (obs_lo),
  .obs_col   (obs_col)
);

// File: tb/dual_agen_bench.sv
module dual_agen_bench;
  localparam int PERIOD = 10;
  localparam int AW = 14;
  localparam int SW = 2;
  localparam int MSK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_unit = 1'b0;
  logic [1:0]    wr_kind = '0;
  logic [SW-1:0] wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic          rd_unit = 1'b0;
  logic [1:0]    rd_kind = '0;
  logic [SW-1:0] rd_sel = '0;
  logic [AW-1:0] rd_data;
  logic          acc_a_en = 1'b0;
  logic [SW-1:0] acc_a_ptr = '0;
  logic [SW-1:0] acc_a_mod = '0;
  logic [AW-1:0] addr_a;
  logic          acc_b_en = 1'b0;
  logic [SW-1:0] acc_b_ptr = '0;
  logic [SW-1:0] acc_b_mod = '0;
  logic [AW-1:0] addr_b;

  dual_agen #(.AW(AW), .NPTR(4)) u_dual_agen (.*);

  always #(PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;
  string tag = "R1";
  // model state: [unit][kind][reg]
  int    mreg [2][3][4];

  function automatic int step_ref(int i, int m, int l);
    int sm;
    int n;
    int p;
    int b;
    sm = (m >= (1 << (AW-1))) ? m - (1 << AW) : m;
    n  = i + sm;
    if (l == 0) return n & MSK;
    p = 1;
    while (p < l) p = p * 2;
    b = (i / p) * p;
    if (n > b + l - 1) n = n - l;
    else if (n < b) n = n + l;
    return n & MSK;
  endfunction

  function automatic int read_ref();
    if (rd_kind == 2'd3) return 0;
    return mreg[rd_unit][rd_kind][rd_sel];
  endfunction

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    if (acc_a_en)
      mreg[0][0][acc_a_ptr] = step_ref(mreg[0][0][acc_a_ptr], mreg[0][1][acc_a_mod],
                                       mreg[0][2][acc_a_ptr]);
    if (acc_b_en)
      mreg[1][0][acc_b_ptr] = step_ref(mreg[1][0][acc_b_ptr], mreg[1][1][acc_b_mod],
                                       mreg[1][2][acc_b_ptr]);
    if (wr_en && wr_kind != 2'd3)
      mreg[wr_unit][wr_kind][wr_sel] = int'(wr_data);
  endtask

  // Compare all outputs in the low phase, then advance one clock.
  task automatic cyc();
    #1;
    chk("addr_a", int'(addr_a), mreg[0][0][acc_a_ptr]);
    chk("addr_b", int'(addr_b), mreg[1][0][acc_b_ptr]);
    chk("rd_data", int'(rd_data), read_ref());
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 1'b0; acc_a_en = 1'b0; acc_b_en = 1'b0;
  endtask

  task automatic wr(int u, int k, int s, int d);
    idle();
    wr_en = 1'b1; wr_unit = 1'(u); wr_kind = 2'(k); wr_sel = SW'(s); wr_data = AW'(d);
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(int u, int k, int s);
    idle();
    rd_unit = 1'(u); rd_kind = 2'(k); rd_sel = SW'(s);
    cyc();
  endtask

  task automatic read_all(int u);
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 4; s++) rd(u, k, s);
  endtask

  task automatic acc(bit ea, int pa, int ma, bit eb, int pb, int mb);
    wr_en = 1'b0;
    acc_a_en = ea; acc_a_ptr = SW'(pa); acc_a_mod = SW'(ma);
    acc_b_en = eb; acc_b_ptr = SW'(pb); acc_b_mod = SW'(mb);
    rd_unit = 1'b0; rd_kind = 2'd0; rd_sel = SW'(pa);
    cyc();
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 3; k++)
        for (int s = 0; s < 4; s++) mreg[u][k][s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    tag = "R1";
    read_all(0);
    read_all(1);

    // R2: write every register, read back; reserved kind ignored
    tag = "R2";
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 3; k++)
        for (int s = 0; s < 4; s++) wr(u, k, s, u * 1000 + k * 100 + s * 7 + 5);
    read_all(0);
    read_all(1);
    wr(0, 3, 1, 12345);
    wr(1, 3, 2, 999);
    read_all(0);
    read_all(1);

    // R3/R4: linear stepping with zero length, positive and negative steps
    tag = "R4";
    wr(0, 0, 0, 100); wr(0, 1, 0, 3); wr(0, 2, 0, 0);
    wr(0, 1, 1, (1 << AW) - 7);
    for (int i = 0; i < 5; i++) acc(1, 0, 0, 0, 0, 0);
    tag = "R3";
    acc(1, 0, 1, 0, 0, 0);
    acc(1, 0, 1, 0, 0, 0);
    tag = "R4";
    wr(0, 0, 1, 16380); wr(0, 2, 1, 0); wr(0, 1, 2, 5);
    acc(1, 1, 2, 0, 0, 0);
    acc(1, 1, 1, 0, 0, 0);
    acc(1, 1, 1, 0, 0, 0);
    rd(0, 0, 1);

    // R5: ring of 10 at base 32, step +4
    tag = "R5";
    wr(0, 0, 2, 39); wr(0, 2, 2, 10); wr(0, 1, 3, 4);
    for (int i = 0; i < 5; i++) acc(1, 2, 3, 0, 0, 0);
    rd(0, 0, 2);

    // R6: step -7 carries below the ring start
    tag = "R6";
    for (int i = 0; i < 4; i++) acc(1, 2, 1, 0, 0, 0);
    rd(0, 0, 2);
    wr(0, 2, 3, 1); wr(0, 0, 3, 50);
    acc(1, 3, 1, 0, 0, 0);
    rd(0, 0, 3);

    // R7: both units in the same cycle
    tag = "R7";
    wr(1, 0, 0, 500); wr(1, 2, 0, 0); wr(1, 1, 0, 2);
    wr(1, 0, 2, 39); wr(1, 2, 2, 6); wr(1, 1, 3, 5);
    for (int i = 0; i < 4; i++) acc(1, 2, 3, 1, 0, 0);
    for (int i = 0; i < 4; i++) acc(1, 0, 0, 1, 2, 3);
    read_all(0);
    read_all(1);

    // R8: write and access on the same pointer
    tag = "R8";
    wr_en = 1'b1; wr_unit = 1'b0; wr_kind = 2'd0; wr_sel = 2'd0; wr_data = AW'(777);
    acc_a_en = 1'b1; acc_a_ptr = 2'd0; acc_a_mod = 2'd0;
    acc_b_en = 1'b1; acc_b_ptr = 2'd0; acc_b_mod = 2'd0;
    cyc();
    idle();
    acc(1, 0, 0, 1, 0, 0);
    wr_en = 1'b1; wr_unit = 1'b1; wr_kind = 2'd0; wr_sel = 2'd2; wr_data = AW'(44);
    acc_b_en = 1'b1; acc_b_ptr = 2'd2; acc_b_mod = 2'd3;
    cyc();
    idle();
    rd(1, 0, 2);

    // R9: access must leave all other registers alone
    tag = "R9";
    for (int i = 0; i < 6; i++) acc(1, i % 4, (i + 1) % 4, 1, (i + 2) % 4, i % 4);
    read_all(0);
    read_all(1);

    // mixed random traffic, compared every cycle
    tag = "R9rand";
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom_range(0, 3);
      wr_en   = ($urandom_range(0, 2) == 0);
      wr_unit = 1'($urandom_range(0, 1));
      wr_kind = 2'(k);
      wr_sel  = SW'($urandom_range(0, 3));
      if (k == 2)      wr_data = AW'($urandom_range(0, 40));
      else if (k == 1) wr_data = AW'(($urandom_range(0, 20) - 10) & MSK);
      else             wr_data = AW'($urandom_range(0, MSK));
      acc_a_en  = 1'($urandom_range(0, 1));
      acc_a_ptr = SW'($urandom_range(0, 3));
      acc_a_mod = SW'($urandom_range(0, 3));
      acc_b_en  = 1'($urandom_range(0, 1));
      acc_b_ptr = SW'($urandom_range(0, 3));
      acc_b_mod = SW'($urandom_range(0, 3));
      rd_unit   = 1'($urandom_range(0, 1));
      rd_kind   = 2'($urandom_range(0, 3));
      rd_sel    = SW'($urandom_range(0, 3));
      cyc();
    end
    idle();
    read_all(0);
    read_all(1);

    finish_run();
  end

endmodule